// File: doc/BRIEF.md
# Multilevel Inverter Switching Pattern Sequencer

This block drives the switching cells of a flying-capacitor multilevel inverter. The block sequences over output cycles. At the first sampling tick of each cycle it reads the digitized capacitor voltages. It compares each voltage with the midpoint of that capacitor's safe band, which gives a small zone number. It then latches the zone number for the whole cycle. On each later tick it emits the next high-side switch word of the pattern assigned to that zone. The words step from all-off up to all-on and back down, so the output voltage is a staircase from the lowest level to the highest and back.

Each pattern sets or clears exactly one switch per tick. The low-side word is always the bitwise complement of the high-side word. A one-clock strobe marks the tick that begins each cycle. A flag reports, for the whole cycle, whether any sampled voltage lay outside its safe band. The load current plays no part in the choice.

The default build has five levels: four switch bits, three capacitor voltages, eight zones and eight ticks per cycle. A parameter selects a seven-level build instead: six switch bits, five voltages, thirty-two zones and twelve ticks per cycle.

Top module: `mlc_pattern_sequencer`

## Requirements
- R1: After reset the high-side word is 0000, the low-side word is 1111, and the start strobe and the out-of-range flag are 0. All of these hold until the first clock edge with `tick_en` high.
- R2: `sw_lo_o` always equals the bitwise inverse of `sw_hi_o`.
- R3: The outputs change only on clock edges with `tick_en` high. Each tick advances one step, and a cycle has 8 steps (0..7). Step 0 outputs 0000 and step 4 outputs 1111. Steps 5, 6 and 7 repeat steps 3, 2 and 1 in that order.
- R4: Voltages are unsigned words in 0.1 V units. v1 is `cap_volt_i[15:0]`, v2 is `[31:16]` and v3 is `[47:32]`. The zone number is {v1 >= 1500, v2 >= 1000, v3 >= 500}, with v1 as bit 2 and v3 as bit 0. A value equal to its midpoint counts as the upper half.
- R5: Steps 1..3 for each zone, written S4..S1 (bit 3 first), are:
  - zone 0: 0001, 0101, 1101
  - zone 1: 0100, 0101, 1101
  - zone 2: 0001, 0011, 1011
  - zone 3: 0010, 0011, 1011
  - zone 4: 1000, 1010, 1110
  - zone 5: 1000, 1100, 1101
  - zone 6: 0100, 0110, 0111
  - zone 7: 1000, 1010, 1011
- R6: Voltages are sampled only on the tick that begins a cycle. Voltage changes at any other tick do not affect the words of the running cycle.
- R7: `cycle_start_o` is high for exactly the one clock that follows the tick which begins a cycle (the step-0 tick). It is low at every other time.
- R8: The safe bands are 1450..1550 for v1, 950..1050 for v2 and 450..550 for v3, with both ends inclusive. `out_of_range_o` goes high together with the start strobe when any sampled voltage lies outside its band, and it holds for the whole cycle. Zone selection for such a voltage is the same as for the nearest in-band value (clamping).
- R9: With LEVELS = 7 the block has 6 switch bits and 12 steps per cycle. The number of set bits at step s is s for s <= 6 and 12 - s otherwise, so step 6 is 111111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Sampling-tick enable, one step per high clock |
| cap_volt_i | input | NCAP*VW (48) | Packed capacitor voltages in 0.1 V units, v1 lowest |
| sw_hi_o | output | NSW (4) | High-side switch word |
| sw_lo_o | output | NSW (4) | Complementary low-side switch word |
| cycle_start_o | output | 1 | One-clock strobe after the tick that begins a cycle |
| out_of_range_o | output | 1 | Sampled voltages left the safe region; held per cycle |

## Verification
Two things can land on the same tick. The tick that closes one cycle also begins the next, so the sampling of new voltages, the capture of the out-of-range flag and the step-0 word all coincide with the wrap of the previous pattern. The bench provokes this by running cycles back to back with fresh voltages applied exactly on the wrapping tick, and by changing the voltages in the middle of a cycle. The scoreboard judges each tick against the word of the zone latched at the start, with the strobe and flag that belong to that start. Inserting idle clocks between ticks also shows that nothing moves without a tick.

// File: rtl/mlc_seq_pkg.sv
package mlc_seq_pkg;

   // Five-level switch-on order per zone: four 2-bit switch positions,
   // position p in bits [2p+1:2p]. A step of height h has positions 0..h-1 on.
   function automatic logic [7:0] five_lvl_order(input logic [2:0] zone);
      logic [7:0] ord;
      case (zone)
         3'd0:    ord = {2'd1, 2'd3, 2'd2, 2'd0};
         3'd1:    ord = {2'd1, 2'd3, 2'd0, 2'd2};
         3'd2:    ord = {2'd2, 2'd3, 2'd1, 2'd0};
         3'd3:    ord = {2'd2, 2'd3, 2'd0, 2'd1};
         3'd4:    ord = {2'd0, 2'd2, 2'd1, 2'd3};
         3'd5:    ord = {2'd1, 2'd0, 2'd2, 2'd3};
         3'd6:    ord = {2'd3, 2'd0, 2'd1, 2'd2};
         default: ord = {2'd2, 2'd0, 2'd1, 2'd3};
      endcase
      return ord;
   endfunction

endpackage

// File: rtl/mlc_zone_classifier.sv
module mlc_zone_classifier #(
   parameter  int LEVELS    = 5,
   parameter  int VW        = 16,
   parameter  int LEVEL_DV  = 500,
   parameter  int HALF_BAND = 50,
   localparam int NCAP      = LEVELS - 2
) (
   input  logic [NCAP*VW-1:0] volt_i,
   output logic [NCAP-1:0]    zone_o,
   output logic               oor_o
);

   logic [NCAP-1:0] out_c;

   // Capacitor k sits at (NCAP-k) level steps; k = 0 is the highest voltage
   // and drives the most significant zone bit.
   for (genvar k = 0; k < NCAP; k++) begin : g_cap
      localparam logic [VW-1:0] MID = VW'((NCAP - k) * LEVEL_DV);
      localparam logic [VW-1:0] LO  = VW'((NCAP - k) * LEVEL_DV - HALF_BAND);
      localparam logic [VW-1:0] HI  = VW'((NCAP - k) * LEVEL_DV + HALF_BAND);
      logic [VW-1:0] v;
      assign v                  = volt_i[k*VW +: VW];
      // midpoint value goes to the upper half; clamping falls out naturally
      assign zone_o[NCAP-1-k]   = (v >= MID);
      assign out_c[k]           = (v < LO) || (v > HI);
   end

   assign oor_o = |out_c;

endmodule

// File: rtl/mlc_step_counter.sv
module mlc_step_counter #(
   parameter  int NSTEP = 8,
   localparam int SW    = $clog2(NSTEP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   output logic          begin_o,
   output logic [SW-1:0] step_nxt_o
);

   localparam logic [SW-1:0] LAST = SW'(NSTEP - 1);

   logic          run_q;
   logic [SW-1:0] step_q;

   // a cycle begins on the first tick after reset or on the tick after LAST
   assign begin_o    = tick_i && (!run_q || (step_q == LAST));
   assign step_nxt_o = begin_o ? '0 : step_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         step_q <= '0;
      end else if (tick_i) begin
         run_q  <= 1'b1;
         step_q <= step_nxt_o;
      end
   end

endmodule

// File: rtl/mlc_pattern_rom.sv
module mlc_pattern_rom
   import mlc_seq_pkg::*;
#(
   parameter  int LEVELS = 5,
   localparam int NSW    = LEVELS - 1,
   localparam int NCAP   = LEVELS - 2,
   localparam int NSTEP  = 2 * NSW,
   localparam int SW     = $clog2(NSTEP)
) (
   input  logic [NCAP-1:0] zone_i,
   input  logic [SW-1:0]   step_i,
   output logic [NSW-1:0]  word_o
);

   int height;

   // rising half climbs one bit per step, falling half mirrors it
   always_comb begin
      if (int'(step_i) <= NSW) height = int'(step_i);
      else                     height = NSTEP - int'(step_i);
   end

   if (LEVELS == 5) begin : g_five
      logic [7:0] ord;
      always_comb begin
         ord    = five_lvl_order(3'(zone_i));
         word_o = '0;
         for (int p = 0; p < 4; p++) begin
            if (p < height) word_o[ord[2*p +: 2]] = 1'b1;
         end
      end
   end else begin : g_rotate
      // larger builds: switch-on order is a rotation starting at zone mod NSW
      always_comb begin
         int base;
         base   = int'(zone_i) % NSW;
         word_o = '0;
         for (int p = 0; p < NSW; p++) begin
            if (p < height) word_o[(base + p) % NSW] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mlc_pattern_sequencer.sv
module mlc_pattern_sequencer #(
   parameter  int LEVELS    = 5,
   parameter  int VW        = 16,
   parameter  int LEVEL_DV  = 500,
   parameter  int HALF_BAND = 50,
   localparam int NSW       = LEVELS - 1,
   localparam int NCAP      = LEVELS - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [NCAP*VW-1:0] cap_volt_i,
   output logic [NSW-1:0]    sw_hi_o,
   output logic [NSW-1:0]    sw_lo_o,
   output logic              cycle_start_o,
   output logic              out_of_range_o
);

   localparam int NSTEP = 2 * NSW;
   localparam int SW    = $clog2(NSTEP);

   // elaboration-time parameter checks
   if (!(LEVELS == 5 || LEVELS == 7)) begin : g_bad_levels
      $error("LEVELS must be 5 or 7");
   end
   if (HALF_BAND <= 0 || HALF_BAND >= LEVEL_DV) begin : g_bad_band
      $error("HALF_BAND must lie between 0 and LEVEL_DV");
   end
   if ((NCAP * LEVEL_DV + HALF_BAND) >= (2 ** VW)) begin : g_bad_width
      $error("VW too narrow for the top capacitor band");
   end

   logic [NCAP-1:0] zone_c, zone_q, zone_sel;
   logic            oor_c, oor_q;
   logic            begin_c;
   logic [SW-1:0]   step_nxt;
   logic [NSW-1:0]  word_c;
   logic [NSW-1:0]  sw_hi_q, sw_lo_q;
   logic            start_q;

   mlc_zone_classifier #(
      .LEVELS(LEVELS), .VW(VW), .LEVEL_DV(LEVEL_DV), .HALF_BAND(HALF_BAND)
   ) i_class (
      .volt_i (cap_volt_i),
      .zone_o (zone_c),
      .oor_o  (oor_c)
   );

   mlc_step_counter #(.NSTEP(NSTEP)) i_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_en),
      .begin_o    (begin_c),
      .step_nxt_o (step_nxt)
   );

   // zone used for the word of this tick: fresh at a cycle start, else held
   assign zone_sel = begin_c ? zone_c : zone_q;

   mlc_pattern_rom #(.LEVELS(LEVELS)) i_rom (
      .zone_i (zone_sel),
      .step_i (step_nxt),
      .word_o (word_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zone_q  <= '0;
         oor_q   <= 1'b0;
         sw_hi_q <= '0;
         sw_lo_q <= '1;
         start_q <= 1'b0;
      end else begin
         start_q <= begin_c;
         if (begin_c) begin
            zone_q <= zone_c;
            oor_q  <= oor_c;
         end
         if (tick_en) begin
            sw_hi_q <= word_c;
            sw_lo_q <= ~word_c;
         end
      end
   end

   assign sw_hi_o        = sw_hi_q;
   assign sw_lo_o        = sw_lo_q;
   assign cycle_start_o  = start_q;
   assign out_of_range_o = oor_q;

endmodule

// File: rtl/mlc_pattern_sequencer_chk.sv
module mlc_pattern_sequencer_chk #(
   parameter  int LEVELS = 5,
   localparam int NSW    = LEVELS - 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           tick_en,
   input logic [NSW-1:0] sw_hi_o,
   input logic [NSW-1:0] sw_lo_o,
   input logic           cycle_start_o,
   input logic           out_of_range_o
);

   // R2
   complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_lo_o == ~sw_hi_o);

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> ($stable(sw_hi_o) && $stable(sw_lo_o)));

   // R3
   one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> ($countones(sw_hi_o ^ $past(sw_hi_o)) <= 1));

   // R3
   start_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_start_o |-> (sw_hi_o == '0));

   // R7
   start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_start_o |-> $past(tick_en));

   // R8
   oor_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_start_o |-> $stable(out_of_range_o));

endmodule

bind mlc_pattern_sequencer mlc_pattern_sequencer_chk #(.LEVELS(LEVELS)) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .tick_en        (tick_en),
   .sw_hi_o        (sw_hi_o),
   .sw_lo_o        (sw_lo_o),
   .cycle_start_o  (cycle_start_o),
   .out_of_range_o (out_of_range_o)
);

// File: tb/test_mlc_pattern_sequencer.sv
`timescale 1ns/1ps
module test_mlc_pattern_sequencer;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_en;
   logic [47:0] volts;
   logic [79:0] volts7;
   logic [3:0]  sw_hi, sw_lo;
   logic        cstart, oor;
   logic [5:0]  sw7_hi, sw7_lo;
   logic        cstart7, oor7;

   always #2 clk = ~clk;   // 250 MHz

   mlc_pattern_sequencer i_mlc_pattern_sequencer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_volt_i(volts),
      .sw_hi_o(sw_hi), .sw_lo_o(sw_lo), .cycle_start_o(cstart),
      .out_of_range_o(oor));

   mlc_pattern_sequencer #(.LEVELS(7), .LEVEL_DV(1000)) i_mlc_pattern_sequencer_l7 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_volt_i(volts7),
      .sw_hi_o(sw7_hi), .sw_lo_o(sw7_lo), .cycle_start_o(cstart7),
      .out_of_range_o(oor7));

   typedef struct {
      logic [3:0] sw;
      logic       st;
      logic       oo;
      string      tag;
   } exp_t;

   exp_t       sb_q[$];
   int         n_chk  = 0;
   int         n_fail = 0;
   bit         done   = 0;
   logic       tick_seen;
   logic [3:0] last_sw = 4'h0;
   int         t7 = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_up();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // expected words written out per zone (R5), mirrored per R3
   function automatic logic [3:0] exp_word(input int zone, input int s);
      logic [3:0] w;
      int k;
      k = (s <= 4) ? s : 8 - s;
      if (k == 0) return 4'b0000;
      if (k == 4) return 4'b1111;
      case (zone)
         0: w = (k == 1) ? 4'b0001 : (k == 2) ? 4'b0101 : 4'b1101;
         1: w = (k == 1) ? 4'b0100 : (k == 2) ? 4'b0101 : 4'b1101;
         2: w = (k == 1) ? 4'b0001 : (k == 2) ? 4'b0011 : 4'b1011;
         3: w = (k == 1) ? 4'b0010 : (k == 2) ? 4'b0011 : 4'b1011;
         4: w = (k == 1) ? 4'b1000 : (k == 2) ? 4'b1010 : 4'b1110;
         5: w = (k == 1) ? 4'b1000 : (k == 2) ? 4'b1100 : 4'b1101;
         6: w = (k == 1) ? 4'b0100 : (k == 2) ? 4'b0110 : 4'b0111;
         default: w = (k == 1) ? 4'b1000 : (k == 2) ? 4'b1010 : 4'b1011;
      endcase
      return w;
   endfunction

   // R4 zone rule
   function automatic int exp_zone(input int v1, input int v2, input int v3);
      return ((v1 >= 1500) ? 4 : 0) + ((v2 >= 1000) ? 2 : 0) + ((v3 >= 500) ? 1 : 0);
   endfunction

   // R8 band rule
   function automatic bit exp_oor(input int v1, input int v2, input int v3);
      return (v1 < 1450) || (v1 > 1550) || (v2 < 950) || (v2 > 1050) ||
             (v3 < 450) || (v3 > 550);
   endfunction

   // driver: one full cycle, voltages applied on the start tick, alternates
   // applied at step 3 (must not matter, R6), optional idle clocks per tick
   task automatic run_cycle(input int v1, input int v2, input int v3,
                            input int a1, input int a2, input int a3,
                            input int gap, input string tag);
      int  z;
      bit  o;
      z = exp_zone(v1, v2, v3);
      o = exp_oor(v1, v2, v3);
      for (int s = 0; s < 8; s++) begin
         if (s == 0)      volts = {16'(v3), 16'(v2), 16'(v1)};
         else if (s == 3) volts = {16'(a3), 16'(a2), 16'(a1)};
         tick_en = 1'b1;
         sb_q.push_back('{exp_word(z, s), (s == 0), o, tag});
         @(negedge clk);
         tick_en = 1'b0;
         repeat (gap) @(negedge clk);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_seen <= 1'b0;
      else        tick_seen <= tick_en;
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(sw_lo == ~sw_hi, "R2", "low-side word", int'(sw_lo), int'(~sw_hi));
         if (tick_seen) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R3", "unexpected tick result", int'(sw_hi), 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(sw_hi == e.sw, e.tag, "switch word", int'(sw_hi), int'(e.sw));
               check(cstart == e.st, "R7", "start strobe", int'(cstart), int'(e.st));
               check(oor == e.oo, "R8", "out-of-range flag", int'(oor), int'(e.oo));
            end
            begin
               int s7, h7;
               s7 = t7 % 12;
               h7 = (s7 <= 6) ? s7 : 12 - s7;
               check($countones(sw7_hi) == h7, "R9", "7-level set bits",
                     $countones(sw7_hi), h7);
               check(cstart7 == (s7 == 0), "R9", "7-level start",
                     int'(cstart7), int'(s7 == 0));
               if (s7 == 6)
                  check(sw7_hi == 6'h3F, "R9", "7-level peak", int'(sw7_hi), 63);
               t7++;
            end
         end else begin
            check(!cstart, "R7", "strobe without tick", int'(cstart), 0);
            check(sw_hi == last_sw, "R3", "word held without tick",
                  int'(sw_hi), int'(last_sw));
         end
         last_sw = sw_hi;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         finish_up();
      end
   end

   initial begin
      rst_n   = 1'b0;
      tick_en = 1'b0;
      volts   = {16'd500, 16'd1000, 16'd1500};
      volts7  = {16'd1000, 16'd2000, 16'd3000, 16'd4000, 16'd5000};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset, no tick yet
      repeat (3) begin
         @(negedge clk);
         check(sw_hi == 4'h0, "R1", "reset high word", int'(sw_hi), 0);
         check(sw_lo == 4'hF, "R1", "reset low word", int'(sw_lo), 15);
         check(!cstart && !oor, "R1", "reset strobe/flag", int'({cstart, oor}), 0);
      end
      // R5: every zone with voltages inside the half-boxes
      for (int z = 0; z < 8; z++) begin
         int v1, v2, v3;
         v1 = z[2] ? 1520 : 1480;
         v2 = z[1] ? 1020 : 980;
         v3 = z[0] ? 520 : 480;
         run_cycle(v1, v2, v3, v1, v2, v3, 0, "R5");
      end
      // R4: exact midpoints go up, one below goes down
      for (int z = 7; z >= 0; z--) begin
         int v1, v2, v3;
         v1 = z[2] ? 1500 : 1499;
         v2 = z[1] ? 1000 : 999;
         v3 = z[0] ? 500 : 499;
         run_cycle(v1, v2, v3, v1, v2, v3, 0, "R4");
      end
      // R6: voltages change mid-cycle to another zone
      run_cycle(1480, 980, 480, 1520, 1020, 520, 0, "R6");
      run_cycle(1520, 980, 520, 1480, 1020, 480, 0, "R6");
      // R8: out-of-band with clamped zones, then band edges, then recovery
      run_cycle(1551, 1000, 449, 1500, 1000, 500, 0, "R8");
      run_cycle(1450, 1050, 550, 1450, 1050, 550, 0, "R8");
      run_cycle(1449, 1051, 500, 1449, 1051, 500, 0, "R8");
      run_cycle(1550, 950, 450, 1550, 950, 450, 0, "R8");
      // R3: ticks separated by idle clocks
      run_cycle(1520, 1020, 480, 1520, 1020, 480, 2, "R3");
      run_cycle(1480, 1020, 520, 1480, 1020, 520, 1, "R3");
      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R3", "scoreboard drained", sb_q.size(), 0);
      finish_up();
   end

endmodule